// File: doc/BRIEF.md
# Spare-IO Shift Repair Remapper

This block sits between the logical signals of one lane and its physical IOs, and it provides spare IOs at the top end of the lane to recover yield. Each logical signal is a W-bit chunk. With repair off, logical signal i drives physical IO i and the spares stay at zero. With repair on, a registered list of failed IO positions pushes every signal at or above a failed position one place toward the spares. Each failed IO then carries zeros. The receive path applies the same mapping in reverse, so the far side recovers the logical order. The transmit and receive networks read the same configuration register. A new setting therefore reaches both directions on the same clock edge.

Both data paths use a valid/ready stream. The remapper holds no data. Valid passes straight from input to output, and ready passes straight from output back to input. Back-pressure at the physical side therefore stalls the logical side in the same cycle, and the data stays unchanged through the stall. The configuration is written with a one-cycle strobe, which is accepted only while the link is idle. Idle means that neither the transmit input nor the receive input has valid asserted. A write whose fault list is invalid is refused and flagged.

Top module: `lane_spare_remap`

## Requirements
- R1: After reset, and whenever repair is disabled, physical IO j carries logical signal j for j < N_SIG. The N_SPARE spare IOs (positions N_SIG and up) are driven with 0, and cfg_err reads 0 after reset.
- R2: With repair enabled and a single failed position f (the other list entries set to spare positions above it), physical IO j carries logical j for j < f and logical j-1 for j > f. Physical IO f is driven with 0.
- R3: The receive path restores the logical order. Logical output i equals the physical input at the slot where the transmit path places signal i, so looping tx_out_data into rx_in_data returns tx_in_data.
- R4: With several failed positions, each failed position adds one place of shift to every signal above it. Every listed position carries 0 on transmit and is skipped on receive.
- R5: A write (cfg_we high at a clock edge) while tx_in_valid or rx_in_valid is high is ignored. The mapping and cfg_err are left unchanged.
- R6: An accepted write takes effect in the cycle after the clock edge that captures it, on the transmit and receive paths together.
- R7: When cfg_en is 1, a write is refused if any index is at least N_SIG+N_SPARE, or if the indices are not strictly ascending, where field k sits at bits [k*IDX_W +: IDX_W]. A refused write keeps the old mapping and sets cfg_err to 1, and an accepted write clears cfg_err. When cfg_en is 0, the indices are not checked.
- R8: tx_out_valid equals tx_in_valid, tx_in_ready equals tx_out_ready, rx_out_valid equals rx_in_valid, and rx_in_ready equals rx_out_ready. The data paths are combinational.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_en | input | 1 | Repair enable carried by the write |
| cfg_fault | input | N_SPARE*IDX_W | Ascending failed IO positions, field k at bits k*IDX_W |
| cfg_err | output | 1 | Last write attempt was refused |
| tx_in_valid | input | 1 | Logical transmit data valid |
| tx_in_ready | output | 1 | Logical transmit ready |
| tx_in_data | input | N_SIG*W | Logical transmit signals, signal i at bits i*W |
| tx_out_valid | output | 1 | Physical transmit valid |
| tx_out_ready | input | 1 | Physical transmit ready |
| tx_out_data | output | (N_SIG+N_SPARE)*W | Physical IO drive, IO j at bits j*W |
| rx_in_valid | input | 1 | Physical receive valid |
| rx_in_ready | output | 1 | Physical receive ready |
| rx_in_data | input | (N_SIG+N_SPARE)*W | Physical IO samples, IO j at bits j*W |
| rx_out_valid | output | 1 | Logical receive valid |
| rx_out_ready | input | 1 | Logical receive ready |
| rx_out_data | output | N_SIG*W | Logical receive signals |

## Verification
The bench builds the block with eight 8-bit signals, two spares and a 4-bit index field. This gives ten physical positions, each of which the index can address. Values from 10 to 15 still fit in the field, so the out-of-range refusal can be exercised. Two spares make double repairs possible, which covers adjacent faults, faults at position 0 and faults on the spares themselves. Equal and descending index pairs can also be formed to test the ordering check.

// File: rtl/lsr_pkg.sv
package lsr_pkg;
  localparam int unsigned LSR_MAX_SPARE = 8;
  localparam int unsigned LSR_FIELD     = 8;

  // Physical slot of logical signal idx given an ascending fault list.
  // Each fault at or below the running position pushes the signal up one.
  function automatic int unsigned shift_slot(int unsigned idx,
                                             logic [LSR_MAX_SPARE*LSR_FIELD-1:0] flist,
                                             int unsigned nf);
    int unsigned p;
    p = idx;
    for (int k = 0; k < LSR_MAX_SPARE; k++) begin
      if (k < nf && 32'(flist[k*LSR_FIELD +: LSR_FIELD]) <= p) p = p + 1;
    end
    return p;
  endfunction
endpackage

// File: rtl/lsr_cfg.sv
module lsr_cfg
  import lsr_pkg::*;
#(
  parameter int unsigned N_SIG   = 8,
  parameter int unsigned N_SPARE = 2,
  parameter int unsigned IDX_W   = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       busy,
  input  logic                       we,
  input  logic                       en,
  input  logic [N_SPARE*IDX_W-1:0]   fault,
  output logic                       err,
  output logic [N_SIG*IDX_W-1:0]     slot
);
  localparam int unsigned NPHY = N_SIG + N_SPARE;

  logic                     en_q;
  logic [N_SPARE*IDX_W-1:0] fault_q;
  logic                     list_ok;
  logic [LSR_MAX_SPARE*LSR_FIELD-1:0] flist;

  always_comb begin
    list_ok = 1'b1;
    if (en) begin
      for (int k = 0; k < N_SPARE; k++) begin
        if (32'(fault[k*IDX_W +: IDX_W]) >= NPHY) list_ok = 1'b0;
        if (k > 0 && fault[k*IDX_W +: IDX_W] <= fault[(k-1)*IDX_W +: IDX_W]) list_ok = 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      fault_q <= '0;
      err     <= 1'b0;
    end else if (we && !busy) begin
      if (list_ok) begin
        en_q    <= en;
        fault_q <= fault;
        err     <= 1'b0;
      end else begin
        err     <= 1'b1;
      end
    end
  end

  always_comb begin
    flist = '0;
    for (int k = 0; k < N_SPARE; k++) flist[k*LSR_FIELD +: LSR_FIELD] = 8'(fault_q[k*IDX_W +: IDX_W]);
  end

  always_comb begin
    for (int i = 0; i < N_SIG; i++)
      slot[i*IDX_W +: IDX_W] = IDX_W'(shift_slot(i, flist, en_q ? N_SPARE : 0));
  end

  p_busy_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    we && busy |=> $stable(en_q) && $stable(fault_q) && $stable(err));
  p_reject_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    we && !busy && !list_ok |=> err && $stable(fault_q));
  p_accept_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    we && !busy && list_ok |=> !err);

  for (genvar k = 0; k < N_SPARE; k++) begin : g_chk
    p_stored_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
      en_q |-> 32'(fault_q[k*IDX_W +: IDX_W]) < NPHY);
  end
endmodule

// File: rtl/lsr_tx_map.sv
module lsr_tx_map #(
  parameter int unsigned N_SIG   = 8,
  parameter int unsigned N_SPARE = 2,
  parameter int unsigned IDX_W   = 4,
  parameter int unsigned W       = 8
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [N_SIG*IDX_W-1:0]          slot,
  input  logic [N_SIG*W-1:0]              in_data,
  output logic [(N_SIG+N_SPARE)*W-1:0]    out_data
);
  localparam int unsigned NPHY = N_SIG + N_SPARE;

  // Gather per physical IO: at most one logical signal claims each slot.
  always_comb begin
    out_data = '0;
    for (int j = 0; j < NPHY; j++) begin
      for (int i = 0; i < N_SIG; i++) begin
        if (32'(slot[i*IDX_W +: IDX_W]) == j) out_data[j*W +: W] = in_data[i*W +: W];
      end
    end
  end

  p_last_in_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    32'(slot[(N_SIG-1)*IDX_W +: IDX_W]) < NPHY);

  for (genvar i = 1; i < N_SIG; i++) begin : g_ord
    p_slot_increasing_r4: assert property (@(posedge clk) disable iff (!rst_n)
      slot[i*IDX_W +: IDX_W] > slot[(i-1)*IDX_W +: IDX_W]);
  end
endmodule

// File: rtl/lsr_rx_map.sv
module lsr_rx_map #(
  parameter int unsigned N_SIG   = 8,
  parameter int unsigned N_SPARE = 2,
  parameter int unsigned IDX_W   = 4,
  parameter int unsigned W       = 8
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [N_SIG*IDX_W-1:0]          slot,
  input  logic [(N_SIG+N_SPARE)*W-1:0]    in_data,
  output logic [N_SIG*W-1:0]              out_data
);
  localparam int unsigned NPHY = N_SIG + N_SPARE;

  always_comb begin
    out_data = '0;
    for (int i = 0; i < N_SIG; i++) begin
      for (int j = 0; j < NPHY; j++) begin
        if (32'(slot[i*IDX_W +: IDX_W]) == j) out_data[i*W +: W] = in_data[j*W +: W];
      end
    end
  end

  p_first_within_spares_r3: assert property (@(posedge clk) disable iff (!rst_n)
    32'(slot[IDX_W-1:0]) <= N_SPARE);
endmodule

// File: rtl/lane_spare_remap.sv
module lane_spare_remap #(
  parameter int unsigned N_SIG   = 8,
  parameter int unsigned N_SPARE = 2,
  parameter int unsigned W       = 8,
  parameter int unsigned IDX_W   = $clog2(N_SIG + N_SPARE + 1)
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            cfg_we,
  input  logic                            cfg_en,
  input  logic [N_SPARE*IDX_W-1:0]        cfg_fault,
  output logic                            cfg_err,
  input  logic                            tx_in_valid,
  output logic                            tx_in_ready,
  input  logic [N_SIG*W-1:0]              tx_in_data,
  output logic                            tx_out_valid,
  input  logic                            tx_out_ready,
  output logic [(N_SIG+N_SPARE)*W-1:0]    tx_out_data,
  input  logic                            rx_in_valid,
  output logic                            rx_in_ready,
  input  logic [(N_SIG+N_SPARE)*W-1:0]    rx_in_data,
  output logic                            rx_out_valid,
  input  logic                            rx_out_ready,
  output logic [N_SIG*W-1:0]              rx_out_data
);
  logic                   busy;
  logic [N_SIG*IDX_W-1:0] slot;

  assign busy         = tx_in_valid | rx_in_valid;
  assign tx_out_valid = tx_in_valid;
  assign tx_in_ready  = tx_out_ready;
  assign rx_out_valid = rx_in_valid;
  assign rx_in_ready  = rx_out_ready;

  lsr_cfg #(.N_SIG(N_SIG), .N_SPARE(N_SPARE), .IDX_W(IDX_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .busy(busy), .we(cfg_we), .en(cfg_en),
    .fault(cfg_fault), .err(cfg_err), .slot(slot));

  lsr_tx_map #(.N_SIG(N_SIG), .N_SPARE(N_SPARE), .IDX_W(IDX_W), .W(W)) u_tx (
    .clk(clk), .rst_n(rst_n), .slot(slot), .in_data(tx_in_data), .out_data(tx_out_data));

  lsr_rx_map #(.N_SIG(N_SIG), .N_SPARE(N_SPARE), .IDX_W(IDX_W), .W(W)) u_rx (
    .clk(clk), .rst_n(rst_n), .slot(slot), .in_data(rx_in_data), .out_data(rx_out_data));

  p_stream_pass_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_out_valid == tx_in_valid) && (rx_in_ready == rx_out_ready));
endmodule

// File: tb/lane_spare_remap_bench.sv
`timescale 1ns/1ps
module lane_spare_remap_bench;
  localparam int N  = 8;
  localparam int S  = 2;
  localparam int W  = 8;
  localparam int IW = 4;
  localparam int NP = N + S;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0, cfg_en = 1'b0;
  logic [S*IW-1:0] cfg_fault = '0;
  logic cfg_err;
  logic tx_in_valid = 1'b0, tx_in_ready, tx_out_valid, tx_out_ready = 1'b0;
  logic rx_in_valid = 1'b0, rx_in_ready, rx_out_valid, rx_out_ready = 1'b0;
  logic [N*W-1:0]  tx_in_data = '0, rx_out_data;
  logic [NP*W-1:0] tx_out_data, rx_in_data = '0;

  int checks = 0, fails = 0;
  bit done = 1'b0;
  bit m_en = 1'b0;
  logic [S*IW-1:0] m_f = '0;
  bit m_err = 1'b0;

  always #2 clk = ~clk;

  lane_spare_remap #(.N_SIG(N), .N_SPARE(S), .W(W), .IDX_W(IW)) u_lane_spare_remap (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_en(cfg_en), .cfg_fault(cfg_fault),
    .cfg_err(cfg_err), .tx_in_valid(tx_in_valid), .tx_in_ready(tx_in_ready),
    .tx_in_data(tx_in_data), .tx_out_valid(tx_out_valid), .tx_out_ready(tx_out_ready),
    .tx_out_data(tx_out_data), .rx_in_valid(rx_in_valid), .rx_in_ready(rx_in_ready),
    .rx_in_data(rx_in_data), .rx_out_valid(rx_out_valid), .rx_out_ready(rx_out_ready),
    .rx_out_data(rx_out_data));

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit is_fault(int j, bit en, logic [S*IW-1:0] f);
    if (!en) return 1'b0;
    for (int k = 0; k < S; k++) if (int'(f[k*IW +: IW]) == j) return 1'b1;
    return 1'b0;
  endfunction

  function automatic logic [NP*W-1:0] exp_tx(logic [N*W-1:0] d, bit en, logic [S*IW-1:0] f);
    logic [NP*W-1:0] o;
    int nx;
    o = '0; nx = 0;
    for (int j = 0; j < NP; j++)
      if (!is_fault(j, en, f) && nx < N) begin o[j*W +: W] = d[nx*W +: W]; nx++; end
    return o;
  endfunction

  function automatic logic [N*W-1:0] exp_rx(logic [NP*W-1:0] p, bit en, logic [S*IW-1:0] f);
    logic [N*W-1:0] o;
    int nx;
    o = '0; nx = 0;
    for (int j = 0; j < NP; j++)
      if (!is_fault(j, en, f) && nx < N) begin o[nx*W +: W] = p[j*W +: W]; nx++; end
    return o;
  endfunction

  function automatic bit list_bad(bit en, logic [S*IW-1:0] f);
    if (!en) return 1'b0;
    for (int k = 0; k < S; k++) begin
      if (int'(f[k*IW +: IW]) >= NP) return 1'b1;
      if (k > 0 && f[k*IW +: IW] <= f[(k-1)*IW +: IW]) return 1'b1;
    end
    return 1'b0;
  endfunction

  // Write at a negedge; result visible after the next negedge (R6).
  task automatic write_cfg(input bit en, input logic [S*IW-1:0] f, input bit busy_tx, input bit busy_rx);
    @(negedge clk);
    cfg_we = 1'b1; cfg_en = en; cfg_fault = f;
    tx_in_valid = busy_tx; rx_in_valid = busy_rx;
    @(negedge clk);
    cfg_we = 1'b0; tx_in_valid = 1'b0; rx_in_valid = 1'b0;
    if (!(busy_tx || busy_rx)) begin
      if (list_bad(en, f)) m_err = 1'b1;
      else begin m_en = en; m_f = f; m_err = 1'b0; end
    end
    #1;
    chk(cfg_err == m_err, "R7/R5 cfg_err", 128'(cfg_err), 128'(m_err));
  endtask

  task automatic data_check(input string req);
    logic [NP*W-1:0] et;
    logic [N*W-1:0] er;
    tx_in_data = {$urandom, $urandom};
    rx_in_data = {$urandom, $urandom, $urandom};
    #1;
    et = exp_tx(tx_in_data, m_en, m_f);
    er = exp_rx(rx_in_data, m_en, m_f);
    chk(tx_out_data == et, {req, " tx map"}, 128'(tx_out_data), 128'(et));
    chk(rx_out_data == er, {req, " rx map"}, 128'(rx_out_data), 128'(er));
    rx_in_data = tx_out_data;
    #1;
    chk(rx_out_data == tx_in_data, "R3 loopback", 128'(rx_out_data), 128'(tx_in_data));
  endtask

  initial begin
    void'($urandom(32'd20250819));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state: identity, spares zero, no error
    chk(cfg_err == 1'b0, "R1 reset err", 128'(cfg_err), 128'd0);
    data_check("R1 reset");
    chk(tx_out_data[N*W +: S*W] == '0, "R1 spares zero", 128'(tx_out_data[N*W +: S*W]), 128'd0);

    // R8 stream pass-through
    for (int t = 0; t < 8; t++) begin
      @(negedge clk);
      tx_in_valid = 1'($urandom); tx_out_ready = 1'($urandom);
      rx_in_valid = 1'($urandom); rx_out_ready = 1'($urandom);
      #1;
      chk({tx_out_valid, tx_in_ready, rx_out_valid, rx_in_ready} ==
          {tx_in_valid, tx_out_ready, rx_in_valid, rx_out_ready}, "R8 handshake",
          128'({tx_out_valid, tx_in_ready, rx_out_valid, rx_in_ready}),
          128'({tx_in_valid, tx_out_ready, rx_in_valid, rx_out_ready}));
    end
    @(negedge clk);
    tx_in_valid = 1'b0; rx_in_valid = 1'b0;

    // R2 single fault (second entry parked on last spare)
    write_cfg(1'b1, {4'd9, 4'd3}, 1'b0, 1'b0);
    data_check("R2 fault 3 / R6");
    chk(tx_out_data[3*W +: W] == '0, "R2 failed IO zero", 128'(tx_out_data[3*W +: W]), 128'd0);
    write_cfg(1'b1, {4'd9, 4'd0}, 1'b0, 1'b0);
    data_check("R2 fault 0");

    // R4 double faults: adjacent, spread, on spares
    write_cfg(1'b1, {4'd5, 4'd4}, 1'b0, 1'b0);
    data_check("R4 adjacent");
    write_cfg(1'b1, {4'd7, 4'd1}, 1'b0, 1'b0);
    data_check("R4 spread");
    chk(tx_out_data[7*W +: W] == '0 && tx_out_data[1*W +: W] == '0, "R4 both zero",
        128'({tx_out_data[7*W +: W], tx_out_data[1*W +: W]}), 128'd0);
    write_cfg(1'b1, {4'd9, 4'd8}, 1'b0, 1'b0);
    data_check("R4 spares only");

    // R5 write while busy is ignored
    write_cfg(1'b1, {4'd6, 4'd2}, 1'b1, 1'b0);
    data_check("R5 busy tx");
    write_cfg(1'b0, {4'd0, 4'd0}, 1'b0, 1'b1);
    data_check("R5 busy rx");

    // R7 refusals keep old mapping
    write_cfg(1'b1, {4'd12, 4'd3}, 1'b0, 1'b0);
    data_check("R7 out of range");
    write_cfg(1'b1, {4'd3, 4'd3}, 1'b0, 1'b0);
    data_check("R7 equal");
    write_cfg(1'b1, {4'd2, 4'd6}, 1'b0, 1'b0);
    data_check("R7 descending");
    write_cfg(1'b1, {4'd15, 4'd10}, 1'b0, 1'b0);
    data_check("R7 both out");
    // disable with garbage indices: accepted, bypass (R1)
    write_cfg(1'b0, {4'd15, 4'd15}, 1'b0, 1'b0);
    data_check("R1 disabled bypass");

    // Random configurations
    for (int t = 0; t < 60; t++) begin
      logic [IW-1:0] a, b;
      a = IW'($urandom % 16);
      b = IW'($urandom % 16);
      if (($urandom % 4) != 0) begin
        a = IW'($urandom % NP);
        b = IW'($urandom % NP);
        if (a > b) begin logic [IW-1:0] tmp; tmp = a; a = b; b = tmp; end
      end
      write_cfg(1'($urandom), {b, a}, ($urandom % 8) == 0, ($urandom % 8) == 0);
      for (int r = 0; r < 3; r++) data_check("R2/R4 random");
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule